// File: doc/BRIEF.md
# Interrupt Message Source with End-of-Interrupt Handshake

This block turns one external interrupt pin into interrupt request messages on a valid/ready output. Software sets it up through a 64-bit definition register. The register is reached as two 32-bit words through a write/read port with a word select. It holds:

- an enable mask,
- the pin's active level,
- a 3-bit message type,
- a 50-bit information payload,
- a flag that lets the message overtake posted writes,
- an enable for the end-of-interrupt (EOI) handshake,
- a status bit that shows the source is waiting for an EOI.

The pin passes through a synchroniser and then a polarity correction. Each change of the pin to its active level raises one request. When the handshake is enabled, every accepted message sets the wait bit. While the wait bit is set, further requests are held. The wait bit is cleared by an EOI pulse, or by software writing one to it. A held request is sent as soon as the wait bit clears.

Top module: `irq_msg_source`

## Requirements
- R1: The mask (low word bit 0) resets to 1. While it is 1, no message is issued. Pin activations that occur while masked are discarded, and so is any request already waiting.
- R2: Low word layout: bit 0 is the mask, bit 1 the polarity, bits 4:2 the type, bit 5 the handshake enable and bits 31:6 payload bits 25:0. High word layout: bits 23:0 are payload bits 49:26, bits 29:24 always read 0, bit 30 is the overtake flag and bit 31 the wait bit. The read data shows the word picked by the select input.
- R3: With polarity 1 the pin is active-low. With polarity 0 it is active-high.
- R4: Each change of the pin to its active level gives exactly one request. A pin held at the active level gives no more. The pin is sampled at a clock edge. A message whose path is free becomes valid after the SYNC_STAGES+2nd clock edge, counting that sampling edge as the first.
- R5: Activations that arrive while a message is outstanding or the source is blocked merge into one held request. That request is issued when the path frees.
- R6: Once valid, a message stays valid with unchanged type, payload and flag until ready is sampled high. Its fields are a snapshot of the register at issue.
- R7: When the handshake enable is 1, the wait bit is set in the same edge that completes the valid/ready transfer. When the enable is 0, the transfer leaves the wait bit unchanged.
- R8: While the handshake enable and the wait bit are both 1, no message is issued. While the enable is 0, the wait bit has no effect on issue.
- R9: An EOI pulse clears the wait bit. If a transfer sets the bit in the same cycle, setting wins.
- R10: Writing the high word with bit 31 = 1 clears the wait bit. Writing it with bit 31 = 0 leaves the wait bit as it was.
- R11: The message carries the type, the 50-bit payload and the overtake flag that were in the register when it was issued.
- R12: After reset the low word reads 0x00000001, the high word reads 0 and no message is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 1 | External interrupt pin (asynchronous) |
| cfg_we_i | input | 1 | Register word write strobe |
| cfg_hi_i | input | 1 | Word select: 0 = bits 31:0, 1 = bits 63:32 |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected word |
| eoi_i | input | 1 | End-of-interrupt pulse |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message ready |
| msg_type_o | output | 3 | Message type |
| msg_info_o | output | 50 | Interrupt information payload |
| msg_passpw_o | output | 1 | Message may overtake posted writes |

## Verification
Two kinds of wrong internal state show up at the ports in different ways.

A wrong held-request flag or a wrong edge history shows up as an extra message or a missing one. This becomes visible at msg_valid_o within one clock of the cycle in which the block would have issued. A stale or wrongly set wait bit shows up the same way when the handshake is enabled. The wait bit is also readable in bit 31 of the high word, so it can be checked in every cycle, even while no pin activity is under way.

Corrupted snapshot fields or register bits show on the message outputs while valid is high, or on the read data at once.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int TYPE_W = 3;
  localparam int INFO_W = 50;
  localparam int INFO_LO_W = 26;
  localparam int INFO_HI_W = INFO_W - INFO_LO_W;

  typedef struct packed {
    logic                mask;
    logic                pol;
    logic [TYPE_W-1:0]   mtype;
    logic                rqeoi;
    logic [INFO_W-1:0]   info;
    logic                passpw;
  } irq_cfg_t;

  typedef struct packed {
    logic [TYPE_W-1:0]   mtype;
    logic [INFO_W-1:0]   info;
    logic                passpw;
  } irq_msg_t;

  // polarity-corrected pin level
  function automatic logic level_active(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction

  function automatic logic [31:0] pack_lo(input irq_cfg_t c);
    return {c.info[INFO_LO_W-1:0], c.rqeoi, c.mtype, c.pol, c.mask};
  endfunction

  function automatic logic [31:0] pack_hi(input irq_cfg_t c, input logic wt);
    return {wt, c.passpw, 6'b000000, c.info[INFO_W-1:INFO_LO_W]};
  endfunction

  function automatic irq_cfg_t apply_wr(input irq_cfg_t c, input logic hi,
                                        input logic [31:0] d);
    irq_cfg_t n;
    n = c;
    if (hi) begin
      n.info[INFO_W-1:INFO_LO_W] = d[INFO_HI_W-1:0];
      n.passpw = d[30];
    end else begin
      n.mask  = d[0];
      n.pol   = d[1];
      n.mtype = d[4:2];
      n.rqeoi = d[5];
      n.info[INFO_LO_W-1:0] = d[31:6];
    end
    return n;
  endfunction

  // hardware set dominates either clear source
  function automatic logic wait_next(input logic cur, input logic set,
                                     input logic eoi, input logic sw_clr);
    if (set) return 1'b1;
    if (eoi || sw_clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_o = chain[STAGES-1];

endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend
  import irq_src_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_i,
  input  logic pol_i,
  input  logic mask_i,
  input  logic take_i,
  output logic act_edge_o,
  output logic pend_o
);

  logic act_now;
  logic act_prev;

  assign act_now    = level_active(pin_sync_i, pol_i);
  assign act_edge_o = act_now & ~act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev <= 1'b0;
      pend_o   <= 1'b0;
    end else begin
      act_prev <= act_now;
      if (take_i) pend_o <= act_edge_o & ~mask_i;
      else        pend_o <= (pend_o | act_edge_o) & ~mask_i;
    end
  end

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !take_i && !mask_i) |=> pend_o);

  // R1
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> !pend_o);

endmodule

// File: rtl/irq_def_regs.sv
module irq_def_regs
  import irq_src_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic        hi_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        set_wait_i,
  input  logic        eoi_i,
  output irq_cfg_t    cfg_o,
  output logic        wait_o
);

  logic sw_clr;

  assign sw_clr  = we_i & hi_i & wdata_i[31];
  assign rdata_o = hi_i ? pack_hi(cfg_o, wait_o) : pack_lo(cfg_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o      <= '0;
      cfg_o.mask <= 1'b1;
      wait_o     <= 1'b0;
    end else begin
      if (we_i) cfg_o <= apply_wr(cfg_o, hi_i, wdata_i);
      wait_o <= wait_next(wait_o, set_wait_i, eoi_i, sw_clr);
    end
  end

  // R7
  wait_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wait_i |=> wait_o);

  // R9
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !set_wait_i) |=> !wait_o);

  // R10
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !set_wait_i) |=> !wait_o);

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wait_i && !eoi_i && !sw_clr) |=> $stable(wait_o));

endmodule

// File: rtl/irq_issue_ctrl.sv
module irq_issue_ctrl
  import irq_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic              mask_i,
  input  logic              rqeoi_i,
  input  logic              wait_i,
  input  logic [TYPE_W-1:0] mtype_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic              passpw_i,
  input  logic              ready_i,
  output logic              valid_o,
  output irq_msg_t          msg_o,
  output logic              take_o,
  output logic              set_wait_o
);

  logic blocked;
  logic fire;

  assign blocked    = rqeoi_i & wait_i;
  assign take_o     = pend_i & ~valid_o & ~mask_i & ~blocked;
  assign fire       = valid_o & ready_i;
  assign set_wait_o = fire & rqeoi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      msg_o   <= '0;
    end else if (take_o) begin
      valid_o      <= 1'b1;
      msg_o.mtype  <= mtype_i;
      msg_o.info   <= info_i;
      msg_o.passpw <= passpw_i;
    end else if (fire) begin
      valid_o <= 1'b0;
    end
  end

  // R8
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rqeoi_i && wait_i) |-> !take_o);

  // R1
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |-> !take_o);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(msg_o)));

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !valid_o);

endmodule

// File: rtl/irq_msg_source.sv
module irq_msg_source
  import irq_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_pin_i,
  input  logic        cfg_we_i,
  input  logic        cfg_hi_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        eoi_i,
  output logic        msg_valid_o,
  input  logic        msg_ready_i,
  output logic [2:0]  msg_type_o,
  output logic [49:0] msg_info_o,
  output logic        msg_passpw_o
);

  logic     pin_sync;
  logic     act_edge;
  logic     pend;
  logic     take;
  logic     set_wait;
  logic     wait_bit;
  irq_cfg_t cfg;
  irq_msg_t msg;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (irq_pin_i),
    .pin_o (pin_sync)
  );

  irq_edge_pend u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_sync_i (pin_sync),
    .pol_i      (cfg.pol),
    .mask_i     (cfg.mask),
    .take_i     (take),
    .act_edge_o (act_edge),
    .pend_o     (pend)
  );

  irq_def_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .hi_i       (cfg_hi_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .set_wait_i (set_wait),
    .eoi_i      (eoi_i),
    .cfg_o      (cfg),
    .wait_o     (wait_bit)
  );

  irq_issue_ctrl u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend),
    .mask_i     (cfg.mask),
    .rqeoi_i    (cfg.rqeoi),
    .wait_i     (wait_bit),
    .mtype_i    (cfg.mtype),
    .info_i     (cfg.info),
    .passpw_i   (cfg.passpw),
    .ready_i    (msg_ready_i),
    .valid_o    (msg_valid_o),
    .msg_o      (msg),
    .take_o     (take),
    .set_wait_o (set_wait)
  );

  assign msg_type_o   = msg.mtype;
  assign msg_info_o   = msg.info;
  assign msg_passpw_o = msg.passpw;

  // R4
  edge_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend && !msg_valid_o));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hi_i |-> (cfg_rdata_o[29:24] == 6'b0));

endmodule

// File: tb/irq_msg_source_tb.sv
`timescale 1ns/1ps
module irq_msg_source_tb;

  localparam int STAGES = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        we = 1'b0;
  logic        hi = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        eoi = 1'b0;
  logic        vld;
  logic        rdy = 1'b0;
  logic [2:0]  mt;
  logic [49:0] inf;
  logic        ppw;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit rnd_rdy = 0;

  always #2.5 clk = ~clk;

  irq_msg_source #(.SYNC_STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .cfg_we_i(we), .cfg_hi_i(hi),
    .cfg_wdata_i(wd), .cfg_rdata_o(rd), .eoi_i(eoi), .msg_valid_o(vld),
    .msg_ready_i(rdy), .msg_type_o(mt), .msg_info_o(inf), .msg_passpw_o(ppw)
  );

  // reference model state
  bit          m_hist[$];
  bit          m_prev, m_pend, m_valid, m_wait;
  bit          m_mask, m_pol, m_rqeoi, m_pp;
  bit [2:0]    m_type;
  bit [49:0]   m_info;
  bit [2:0]    o_type;
  bit [49:0]   o_info;
  bit          o_pp;

  task automatic m_reset();
    m_hist.delete();
    for (int i = 0; i < STAGES; i++) m_hist.push_back(1'b0);
    m_prev = 0; m_pend = 0; m_valid = 0; m_wait = 0;
    m_mask = 1; m_pol = 0; m_rqeoi = 0; m_pp = 0; m_type = 0; m_info = 0;
    o_type = 0; o_info = 0; o_pp = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit act, edg, take, fire, nwait, npend;
      act   = m_hist[STAGES-1] ^ m_pol;
      edg   = act && !m_prev;
      take  = m_pend && !m_valid && !m_mask && !(m_rqeoi && m_wait);
      fire  = m_valid && rdy;
      if (fire && m_rqeoi) nwait = 1;
      else if (eoi || (we && hi && wd[31])) nwait = 0;
      else nwait = m_wait;
      npend = take ? (edg && !m_mask) : ((m_pend || edg) && !m_mask);
      if (take) begin
        m_valid = 1; o_type = m_type; o_info = m_info; o_pp = m_pp;
      end else if (fire) m_valid = 0;
      void'(m_hist.pop_back());
      m_hist.push_front(pin);
      m_prev = act; m_pend = npend; m_wait = nwait;
      if (we) begin
        if (hi) begin
          m_info[49:26] = wd[23:0]; m_pp = wd[30];
        end else begin
          m_mask = wd[0]; m_pol = wd[1]; m_type = wd[4:2]; m_rqeoi = wd[5];
          m_info[25:0] = wd[31:6];
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input bit h);
    logic [31:0] w;
    w = '0;
    if (h) begin
      w[23:0] = m_info[49:26]; w[30] = m_pp; w[31] = m_wait;
    end else begin
      w[0] = m_mask; w[1] = m_pol; w[4:2] = m_type; w[5] = m_rqeoi;
      w[31:6] = m_info[25:0];
    end
    return w;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R1 R3 R4 R5 R8 R12: issue timing
      check(vld === m_valid, "R1 R3 R4 R5 R8 R12 valid", 64'(vld), 64'(m_valid));
      if (m_valid) begin
        // R6 R11: held contents
        check({mt, inf, ppw} === {o_type, o_info, o_pp}, "R6 R11 payload",
              64'({mt, inf, ppw}), 64'({o_type, o_info, o_pp}));
      end
      // R2 R7 R9 R10 R12: register view
      check(rd === exp_word(hi), "R2 R7 R9 R10 R12 rdata", 64'(rd), 64'(exp_word(hi)));
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
    if (rnd_rdy) rdy = 1'($urandom_range(0, 1));
  endtask

  task automatic wr(input bit h, input logic [31:0] d);
    cyc(); we = 1; hi = h; wd = d;
    cyc(); we = 0; wd = '0;
  endtask

  task automatic pulse(input bit active_low, input int len);
    pin = ~active_low;
    repeat (len) cyc();
    pin = active_low;
    repeat (3) cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc(); hi = 1; cyc(); hi = 0; cyc();           // R12 reset readback both words
    // R1: masked pulse gives nothing
    pulse(0, 4); repeat (6) cyc();
    // R2 R11: program payload, reserved bits written as ones
    wr(1, 32'h7F12_3456);
    wr(0, 32'hF8AB_CD54);                           // mask 0, pol 0, type 5, rqeoi 0
    hi = 1; cyc(); hi = 0;
    // R4 R6: ready low holds message
    pulse(0, 5); repeat (8) cyc();
    rdy = 1; cyc(); rdy = 0;
    // R5: several pulses while valid merge
    pulse(0, 2); pulse(0, 2); pulse(0, 2); repeat (6) cyc();
    rdy = 1; repeat (3) cyc(); rdy = 0; repeat (6) cyc();
    rdy = 1; repeat (4) cyc();
    // R4: level held stays one message
    pin = 1; repeat (20) cyc(); pin = 0; repeat (4) cyc();
    // R3: active low
    wr(0, 32'h1234_5666);                           // pol 1, type 1, rqeoi 1
    pin = 1; repeat (6) cyc();                      // idle high
    pin = 0; repeat (6) cyc(); pin = 1; repeat (6) cyc();
    // R7 R8: wait set, second pulse held
    hi = 1; cyc();
    pin = 0; repeat (3) cyc(); pin = 1; repeat (10) cyc();
    // R10: write 0 to wait bit no effect, then write 1 clears
    wr(1, 32'h0000_00AA); repeat (3) cyc();
    wr(1, 32'h8000_00AA); repeat (8) cyc();
    // R9: eoi releases
    pin = 0; repeat (3) cyc(); pin = 1; repeat (8) cyc();
    eoi = 1; cyc(); eoi = 0; repeat (8) cyc();
    // R8: enable off, stale wait ignored
    wr(0, 32'h0000_0046);
    pin = 0; repeat (3) cyc(); pin = 1; repeat (8) cyc();
    hi = 0;
    // random phase
    rnd_rdy = 1;
    for (int i = 0; i < 4000; i++) begin
      cyc();
      if ($urandom_range(0, 6) == 0) pin = ~pin;
      eoi = ($urandom_range(0, 9) == 0);
      hi = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 60) == 0) begin
        we = 1;
        wd = $urandom;
        if (!hi) wd[0] = ($urandom_range(0, 7) == 0);
      end else we = 0;
    end
    we = 0; eoi = 0; rnd_rdy = 0; rdy = 1;
    repeat (20) cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule